// File: doc/BRIEF.md
# NOR Flash Write-Command Sequencer

This block models the write-command front end of a 4M x16 parallel NOR flash. It watches the chip-enable, write-enable and output-enable pins together with the address and data buses. It decodes multi-cycle software command sequences into word program, sector erase, block erase and chip erase operations. It can suspend and resume a running erase. It rejects changes to a boot block when the write-protect pin is low. A device-reset pin aborts whatever is in flight.

While an operation runs, a read returns a status word instead of array contents. In that word, a polling bit carries the complement of bit 7 of the programmed data, and a toggle bit flips on every new read. A parameterised countdown stands in for program and erase time. A small tag-matched store stands in for the flash array, and every address it does not hold reads as erased.

The bus pins are plain, with no valid/ready pair and no back-pressure. A write cycle is taken when `we_n` falls while `ce_n` is low. Writes that arrive during an operation are dropped, except for the suspend and resume bytes. The host finds out when an operation has finished by polling, because the block has no ready pin.

Top module: `nor_cmd_seq`

## Requirements
- R1: A write is taken on the first cycle that `we_n` is low while `ce_n` is low, after `we_n` was high in the previous cycle. Command matching looks only at `addr[10:0]` and `wdata[7:0]`, and the higher bits are ignored. The program sequence is AAh at 555h, then 55h at 2AAh, then A0h at 555h, then the data word at the target address.
- R2: Programming can only clear bits: the stored word becomes old AND new. Words that were never programmed read FFFFh.
- R3: A write that does not fit the sequence expected at that point returns the decoder to read mode and changes nothing.
- R4: The erase prefix is AAh at 555h, 55h at 2AAh, 80h at 555h, AAh at 555h, 55h at 2AAh. The sixth write then selects the operation: 50h erases the sector selected by `addr[21:11]`, 30h erases the block selected by `addr[21:15]`, and 10h at 555h erases the whole chip. Every word in the chosen range then reads FFFFh, and words outside it keep their value.
- R5: With `wp_n` low, a program, sector erase or block erase whose `addr[21:15]` falls in the boot block is rejected and no busy phase starts. The boot block is all ones when TOP_BOOT=1 and all zeros when TOP_BOOT=0. A chip erase with `wp_n` low erases everything except the boot block.
- R6: After the launching write, reads return status for exactly PROG_CYC cycles for a program and ERASE_CYC cycles for an erase. After that, array data returns with the operation applied.
- R7: The status word has bit 7 equal to the complement of data bit 7 during a program and 0 during an erase. Bit 6 flips after each new read, which starts when `oe_n` falls while `ce_n` is low. All other bits are 0.
- R8: Writes that arrive during a busy phase are ignored, apart from the suspend and resume bytes of R9.
- R9: Writing B0h at any address during an erase suspends it. While suspended, reads return array contents, the countdown is frozen, and the erase has not yet been applied. Writing 30h resumes the erase.
- R10: While `hw_rst_n` is low, any partial sequence is dropped and any running operation is abandoned without being applied. Stored data is kept.
- R11: `rdata_oe` is high only when both `ce_n` and `oe_n` are low. `rdata` is 0 whenever `rdata_oe` is low.
- R12: After `rst_n`, every word reads FFFFh and the block is in read mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low; empties the array |
| hw_rst_n | input | 1 | Device reset pin, active low; keeps stored data |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| wp_n | input | 1 | Boot-block write protect, active low |
| addr | input | ADDR_W | Word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data or status word |
| rdata_oe | output | 1 | High when `rdata` is being driven |

## Verification
A decoder stuck in the wrong state shows up on the first read after the final write of a sequence. That read returns array data where status was expected, or status where array data was expected. An off-by-one in the countdown moves the polling bit's return to data by one cycle, and the bench counts that per cycle. A mismatched tag or a wrong erase-range compare shows up on the next read of the affected word or of a word next to it. A wrong suspend or protection path shows up on the read made directly after the B0h write or after the rejected launch.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

  localparam int CMD_AW = 11;

  localparam logic [CMD_AW-1:0] ADR_KEY_A = 11'h555;
  localparam logic [CMD_AW-1:0] ADR_KEY_B = 11'h2AA;

  localparam logic [7:0] BYTE_KEY_A   = 8'hAA;
  localparam logic [7:0] BYTE_KEY_B   = 8'h55;
  localparam logic [7:0] BYTE_PROG    = 8'hA0;
  localparam logic [7:0] BYTE_ERASE   = 8'h80;
  localparam logic [7:0] BYTE_SECTOR  = 8'h50;
  localparam logic [7:0] BYTE_BLOCK   = 8'h30;
  localparam logic [7:0] BYTE_CHIP    = 8'h10;
  localparam logic [7:0] BYTE_SUSPEND = 8'hB0;
  localparam logic [7:0] BYTE_RESUME  = 8'h30;

  localparam int POLL_BIT   = 7;
  localparam int TOGGLE_BIT = 6;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_PROG,
    OP_SECT,
    OP_BLK,
    OP_CHIP
  } op_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_KEY1,
    SQ_KEY2,
    SQ_PDATA,
    SQ_EKEY0,
    SQ_EKEY1,
    SQ_EKEY2
  } seq_e;

endpackage

// File: rtl/nor_cmd_decode.sv
module nor_cmd_decode
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_rst_n,
  input  logic              wr_ev,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              engine_busy,
  output logic              launch,
  output op_e               launch_op,
  output logic [ADDR_W-1:0] launch_addr,
  output logic [DATA_W-1:0] launch_data
);

  seq_e state, nxt;
  logic [CMD_AW-1:0] lo;
  logic [7:0]        cb;
  logic              at_a, at_b;

  assign lo   = wr_addr[CMD_AW-1:0];
  assign cb   = wr_data[7:0];
  assign at_a = (lo == ADR_KEY_A);
  assign at_b = (lo == ADR_KEY_B);

  assign launch_addr = wr_addr;
  assign launch_data = wr_data;

  always_comb begin
    nxt       = state;
    launch    = 1'b0;
    launch_op = OP_NONE;
    if (wr_ev && !engine_busy) begin
      nxt = SQ_IDLE;
      unique case (state)
        SQ_IDLE:  if (at_a && cb == BYTE_KEY_A) nxt = SQ_KEY1;
        SQ_KEY1:  if (at_b && cb == BYTE_KEY_B) nxt = SQ_KEY2;
        SQ_KEY2: begin
          if (at_a && cb == BYTE_PROG)       nxt = SQ_PDATA;
          else if (at_a && cb == BYTE_ERASE) nxt = SQ_EKEY0;
        end
        SQ_PDATA: begin
          launch    = 1'b1;
          launch_op = OP_PROG;
        end
        SQ_EKEY0: if (at_a && cb == BYTE_KEY_A) nxt = SQ_EKEY1;
        SQ_EKEY1: if (at_b && cb == BYTE_KEY_B) nxt = SQ_EKEY2;
        SQ_EKEY2: begin
          if (cb == BYTE_SECTOR) begin
            launch    = 1'b1;
            launch_op = OP_SECT;
          end else if (cb == BYTE_BLOCK) begin
            launch    = 1'b1;
            launch_op = OP_BLK;
          end else if (at_a && cb == BYTE_CHIP) begin
            launch    = 1'b1;
            launch_op = OP_CHIP;
          end
        end
        default: nxt = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         state <= SQ_IDLE;
    else if (!hw_rst_n) state <= SQ_IDLE;
    else                state <= nxt;
  end

  // R10: the device reset pin always leaves the decoder in read mode
  assert_idle_after_hwrst_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !hw_rst_n |=> (state == SQ_IDLE));

endmodule

// File: rtl/nor_op_engine.sv
module nor_op_engine
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W    = 22,
  parameter int DATA_W    = 16,
  parameter int BLOCK_AW  = 15,
  parameter bit TOP_BOOT  = 1'b1,
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_rst_n,
  input  logic              wp_n,
  input  logic              launch,
  input  op_e               launch_op,
  input  logic [ADDR_W-1:0] launch_addr,
  input  logic [DATA_W-1:0] launch_data,
  input  logic              wr_ev,
  input  logic [7:0]        wr_byte,
  input  logic              rd_ev,
  output logic              busy,
  output logic              show_status,
  output logic [DATA_W-1:0] status_word,
  output logic              commit,
  output op_e               commit_op,
  output logic [ADDR_W-1:0] commit_addr,
  output logic [DATA_W-1:0] commit_data,
  output logic              commit_keep_boot
);

  localparam int BLK_W   = ADDR_W - BLOCK_AW;
  localparam int CNT_MAX = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [BLK_W-1:0] BOOT_BLK = TOP_BOOT ? {BLK_W{1'b1}} : {BLK_W{1'b0}};

  op_e               op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              keep_q;
  logic              susp;
  logic              tgl;
  logic [CNT_W-1:0]  cnt;
  logic              is_erase, prot, susp_req, res_req;

  assign is_erase = (op_q == OP_SECT) || (op_q == OP_BLK) || (op_q == OP_CHIP);
  assign prot     = !wp_n && (launch_op != OP_CHIP) &&
                    (launch_addr[ADDR_W-1:BLOCK_AW] == BOOT_BLK);
  assign susp_req = busy && !susp && is_erase && wr_ev && (wr_byte == BYTE_SUSPEND);
  assign res_req  = busy && susp && wr_ev && (wr_byte == BYTE_RESUME);
  assign commit   = busy && !susp && !susp_req && (cnt == CNT_W'(1));

  assign show_status      = busy && !susp;
  assign commit_op        = op_q;
  assign commit_addr      = addr_q;
  assign commit_data      = data_q;
  assign commit_keep_boot = keep_q;

  always_comb begin
    status_word             = '0;
    status_word[POLL_BIT]   = (op_q == OP_PROG) ? ~data_q[7] : 1'b0;
    status_word[TOGGLE_BIT] = tgl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      susp   <= 1'b0;
      op_q   <= OP_NONE;
      addr_q <= '0;
      data_q <= '0;
      keep_q <= 1'b0;
      cnt    <= '0;
    end else if (!hw_rst_n) begin
      busy <= 1'b0;
      susp <= 1'b0;
    end else if (launch && !prot) begin
      busy   <= 1'b1;
      susp   <= 1'b0;
      op_q   <= launch_op;
      addr_q <= launch_addr;
      data_q <= launch_data;
      keep_q <= !wp_n;
      cnt    <= (launch_op == OP_PROG) ? CNT_W'(PROG_CYC) : CNT_W'(ERASE_CYC);
    end else if (commit) begin
      busy <= 1'b0;
    end else if (susp_req) begin
      susp <= 1'b1;
    end else if (res_req) begin
      susp <= 1'b0;
    end else if (busy && !susp) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    tgl <= 1'b0;
    else if (rd_ev && show_status) tgl <= ~tgl;
  end

  // R5: a protected launch never opens a busy phase
  assert_reject_protected_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && prot && !busy) |=> !busy);

  // R8: the decoder never launches while an operation is running
  assert_no_launch_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> !busy);

  // R7: every new read during status flips the toggle bit
  assert_toggle_flip_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ev && show_status) |=> (tgl != $past(tgl)));

  // R9: only an erase can be in the suspended state
  assert_susp_erase_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    susp |-> (busy && is_erase));

  // R6: a running countdown stays within its loaded range
  assert_cnt_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt != '0 && cnt <= CNT_W'(CNT_MAX)));

endmodule

// File: rtl/nor_sparse_array.sv
module nor_sparse_array
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W    = 22,
  parameter int DATA_W    = 16,
  parameter int SECTOR_AW = 11,
  parameter int BLOCK_AW  = 15,
  parameter bit TOP_BOOT  = 1'b1,
  parameter int ENTRIES   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              commit,
  input  op_e               c_op,
  input  logic [ADDR_W-1:0] c_addr,
  input  logic [DATA_W-1:0] c_data,
  input  logic              c_keep_boot
);

  localparam int BLK_W = ADDR_W - BLOCK_AW;
  localparam logic [BLK_W-1:0] BOOT_BLK = TOP_BOOT ? {BLK_W{1'b1}} : {BLK_W{1'b0}};

  logic [ENTRIES-1:0] vld, rd_hit, wr_hit, kill, alloc;
  logic [ADDR_W-1:0]  tag [ENTRIES];
  logic [DATA_W-1:0]  dat [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic sec_eq, blk_eq, in_boot;
    assign sec_eq  = tag[i][ADDR_W-1:SECTOR_AW] == c_addr[ADDR_W-1:SECTOR_AW];
    assign blk_eq  = tag[i][ADDR_W-1:BLOCK_AW] == c_addr[ADDR_W-1:BLOCK_AW];
    assign in_boot = tag[i][ADDR_W-1:BLOCK_AW] == BOOT_BLK;
    assign rd_hit[i] = vld[i] && (tag[i] == rd_addr);
    assign wr_hit[i] = vld[i] && (tag[i] == c_addr);
    assign kill[i]   = vld[i] && (((c_op == OP_SECT) && sec_eq) ||
                                  ((c_op == OP_BLK)  && blk_eq) ||
                                  ((c_op == OP_CHIP) && !(c_keep_boot && in_boot)));
  end

  always_comb begin
    logic found;
    alloc = '0;
    found = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!vld[i] && !found) begin
        alloc[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  always_comb begin
    rd_data = '1;
    for (int i = 0; i < ENTRIES; i++) begin
      if (rd_hit[i]) rd_data = dat[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0;
    end else if (commit) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (c_op == OP_PROG) begin
          if (wr_hit[i]) begin
            dat[i] <= dat[i] & c_data;
          end else if ((wr_hit == '0) && alloc[i]) begin
            vld[i] <= 1'b1;
            tag[i] <= c_addr;
            dat[i] <= c_data;
          end
        end else if (kill[i]) begin
          vld[i] <= 1'b0;
        end
      end
    end
  end

  // R2: one address is never held by two entries
  assert_single_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rd_hit));

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W    = 22,
  parameter int DATA_W    = 16,
  parameter int SECTOR_AW = 11,
  parameter int BLOCK_AW  = 15,
  parameter bit TOP_BOOT  = 1'b1,
  parameter int ENTRIES   = 16,
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              wp_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_oe
);

  logic we_q, oe_q, wr_ev, rd_ev;
  logic launch, busy, show_status, commit, keep_boot;
  op_e  launch_op, commit_op;
  logic [ADDR_W-1:0] launch_addr, commit_addr;
  logic [DATA_W-1:0] launch_data, commit_data, status_word, arr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q <= 1'b1;
      oe_q <= 1'b1;
    end else begin
      we_q <= we_n;
      oe_q <= oe_n;
    end
  end

  assign wr_ev = hw_rst_n && !ce_n && !we_n && we_q;
  assign rd_ev = !ce_n && !oe_n && oe_q;

  nor_cmd_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .hw_rst_n(hw_rst_n),
    .wr_ev(wr_ev), .wr_addr(addr), .wr_data(wdata), .engine_busy(busy),
    .launch(launch), .launch_op(launch_op),
    .launch_addr(launch_addr), .launch_data(launch_data)
  );

  nor_op_engine #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLOCK_AW(BLOCK_AW), .TOP_BOOT(TOP_BOOT),
    .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
  ) u_eng (
    .clk(clk), .rst_n(rst_n), .hw_rst_n(hw_rst_n), .wp_n(wp_n),
    .launch(launch), .launch_op(launch_op),
    .launch_addr(launch_addr), .launch_data(launch_data),
    .wr_ev(wr_ev), .wr_byte(wdata[7:0]), .rd_ev(rd_ev),
    .busy(busy), .show_status(show_status), .status_word(status_word),
    .commit(commit), .commit_op(commit_op), .commit_addr(commit_addr),
    .commit_data(commit_data), .commit_keep_boot(keep_boot)
  );

  nor_sparse_array #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECTOR_AW(SECTOR_AW),
    .BLOCK_AW(BLOCK_AW), .TOP_BOOT(TOP_BOOT), .ENTRIES(ENTRIES)
  ) u_arr (
    .clk(clk), .rst_n(rst_n), .rd_addr(addr), .rd_data(arr_data),
    .commit(commit), .c_op(commit_op), .c_addr(commit_addr),
    .c_data(commit_data), .c_keep_boot(keep_boot)
  );

  assign rdata_oe = !ce_n && !oe_n;
  assign rdata    = rdata_oe ? (show_status ? status_word : arr_data) : '0;

  // R11: the read bus is quiet while either enable is high
  assert_quiet_bus_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rdata_oe |-> (rdata == '0));

endmodule

// File: tb/nor_cmd_seq_tb.sv
`timescale 1ns/1ps
module nor_cmd_seq_tb;

  localparam int AW = 22;
  localparam int PC = 8;
  localparam int EC = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0, hw_rst_n = 1'b1;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, wp_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic rdata_oe;

  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  nor_cmd_seq #(.PROG_CYC(PC), .ERASE_CYC(EC)) u_dut (
    .clk(clk), .rst_n(rst_n), .hw_rst_n(hw_rst_n), .ce_n(ce_n), .we_n(we_n),
    .oe_n(oe_n), .wp_n(wp_n), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rdata_oe(rdata_oe)
  );

  localparam logic [AW-1:0] X1 = 22'h010010;
  localparam logic [AW-1:0] X2 = 22'h010810;
  localparam logic [AW-1:0] X3 = 22'h020010;
  localparam logic [AW-1:0] BT = 22'h3F8004;

  // vector: kind(0 write,1 read-compare,2 wait) | addr | data | requirement
  localparam int NV = 48;
  localparam logic [43:0] VEC [NV] = '{
    {2'd0, 22'h000555, 16'h00AA, 4'd1},  // R1 program, noisy upper bits
    {2'd0, 22'h0002AA, 16'h0055, 4'd1},
    {2'd0, 22'h3FFD55, 16'h12A0, 4'd1},
    {2'd0, X1,         16'h1234, 4'd1},
    {2'd2, 22'h0,      16'd12,   4'd1},
    {2'd1, X1,         16'h1234, 4'd1},
    {2'd0, 22'h000555, 16'h00AA, 4'd2},  // R2 bits only clear
    {2'd0, 22'h0002AA, 16'h0055, 4'd2},
    {2'd0, 22'h000555, 16'h00A0, 4'd2},
    {2'd0, X1,         16'h0F0F, 4'd2},
    {2'd2, 22'h0,      16'd12,   4'd2},
    {2'd1, X1,         16'h0204, 4'd2},
    {2'd1, X2,         16'hFFFF, 4'd2},
    {2'd0, 22'h000555, 16'h00AA, 4'd3},  // R3 broken unlock
    {2'd0, 22'h0002AB, 16'h0055, 4'd3},
    {2'd0, 22'h000555, 16'h00A0, 4'd3},
    {2'd0, X2,         16'h0000, 4'd3},
    {2'd2, 22'h0,      16'd12,   4'd3},
    {2'd1, X2,         16'hFFFF, 4'd3},
    {2'd0, 22'h000555, 16'h00AA, 4'd4},  // R4 setup X2
    {2'd0, 22'h0002AA, 16'h0055, 4'd4},
    {2'd0, 22'h000555, 16'h00A0, 4'd4},
    {2'd0, X2,         16'h5A5A, 4'd4},
    {2'd2, 22'h0,      16'd12,   4'd4},
    {2'd0, 22'h000555, 16'h00AA, 4'd4},  // R4 setup X3
    {2'd0, 22'h0002AA, 16'h0055, 4'd4},
    {2'd0, 22'h000555, 16'h00A0, 4'd4},
    {2'd0, X3,         16'h1111, 4'd4},
    {2'd2, 22'h0,      16'd12,   4'd4},
    {2'd0, 22'h000555, 16'h00AA, 4'd4},  // R4 sector erase at X1
    {2'd0, 22'h0002AA, 16'h0055, 4'd4},
    {2'd0, 22'h000555, 16'h0080, 4'd4},
    {2'd0, 22'h000555, 16'h00AA, 4'd4},
    {2'd0, 22'h0002AA, 16'h0055, 4'd4},
    {2'd0, X1,         16'h0050, 4'd4},
    {2'd2, 22'h0,      16'd30,   4'd4},
    {2'd1, X1,         16'hFFFF, 4'd4},
    {2'd1, X2,         16'h5A5A, 4'd4},
    {2'd1, X3,         16'h1111, 4'd4},
    {2'd0, 22'h000555, 16'h00AA, 4'd4},  // R4 block erase at X2
    {2'd0, 22'h0002AA, 16'h0055, 4'd4},
    {2'd0, 22'h000555, 16'h0080, 4'd4},
    {2'd0, 22'h000555, 16'h00AA, 4'd4},
    {2'd0, 22'h0002AA, 16'h0055, 4'd4},
    {2'd0, X2,         16'h0030, 4'd4},
    {2'd2, 22'h0,      16'd30,   4'd4},
    {2'd1, X2,         16'hFFFF, 4'd4},
    {2'd1, X3,         16'h1111, 4'd4}
  };

  task automatic chk(input int req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk);
    we_n = 1'b1; ce_n = 1'b1;
  endtask

  task automatic bus_rd(input logic [AW-1:0] a, output logic [15:0] v);
    @(negedge clk);
    addr = a; ce_n = 1'b0; oe_n = 1'b0;
    #1 v = rdata;
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic unlock3(input logic [7:0] third);
    bus_wr(22'h000555, 16'h00AA);
    bus_wr(22'h0002AA, 16'h0055);
    bus_wr(22'h000555, {8'h00, third});
  endtask

  task automatic erase_pre;
    unlock3(8'h80);
    bus_wr(22'h000555, 16'h00AA);
    bus_wr(22'h0002AA, 16'h0055);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, v2;
    int bcnt;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R12 reset state and R11 quiet bus
    #1 chk(11, {15'd0, rdata_oe}, 16'h0000);
    chk(11, rdata, 16'h0000);
    bus_rd(X1, v); chk(12, v, 16'hFFFF);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] k; logic [AW-1:0] a; logic [15:0] d; int r;
      k = VEC[i][43:42]; a = VEC[i][41:20]; d = VEC[i][19:4]; r = int'(VEC[i][3:0]);
      case (k)
        2'd0: bus_wr(a, d);
        2'd1: begin bus_rd(a, v); chk(r, v, d); end
        default: idle(int'(d));
      endcase
    end

    // R6 exact busy length with polling bit (data bit7=0 -> status bit7=1)
    unlock3(8'hA0);
    @(negedge clk);
    addr = X1; wdata = 16'h0055; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk);
    we_n = 1'b1; oe_n = 1'b0;
    bcnt = 0;
    for (int k = 0; k < 100; k++) begin
      #1;
      if (rdata[7]) bcnt++;
      else break;
      @(negedge clk);
    end
    chk(6, 16'(bcnt), 16'(PC));
    chk(6, rdata, 16'h0055);
    @(negedge clk); ce_n = 1'b1; oe_n = 1'b1;

    // R7 toggle and polling bit during program
    unlock3(8'hA0);
    bus_wr(X2, 16'h00F0);
    bus_rd(X2, v); bus_rd(X2, v2);
    chk(7, {15'd0, v[6] ^ v2[6]}, 16'h0001);
    chk(7, v & 16'hFFBF, 16'h0000);
    idle(12);
    bus_rd(X2, v); chk(7, v, 16'h00F0);

    // R8 writes during an erase are dropped; R7 erase status
    erase_pre; bus_wr(X3, 16'h0050);
    unlock3(8'hA0); bus_wr(X1, 16'h0000);
    bus_rd(X3, v); chk(7, v & 16'hFFBF, 16'h0000);
    idle(EC + 4);
    bus_rd(X1, v); chk(8, v, 16'h0055);
    bus_rd(X3, v); chk(8, v, 16'hFFFF);

    // R9 suspend and resume
    unlock3(8'hA0); bus_wr(X3, 16'h7777); idle(12);
    erase_pre; bus_wr(X3, 16'h0050);
    idle(3);
    bus_wr(22'h000000, 16'h00B0);
    bus_rd(X3, v); chk(9, v, 16'h7777);
    idle(EC + 10);
    bus_rd(X3, v); chk(9, v, 16'h7777);
    bus_wr(22'h000000, 16'h0030);
    bus_rd(X3, v); chk(9, v & 16'hFFBF, 16'h0000);
    idle(EC + 4);
    bus_rd(X3, v); chk(9, v, 16'hFFFF);

    // R5 boot-block protection
    wp_n = 1'b0;
    unlock3(8'hA0); bus_wr(BT, 16'h0000);
    bus_rd(BT, v); chk(5, v, 16'hFFFF);
    idle(12);
    bus_rd(BT, v); chk(5, v, 16'hFFFF);
    wp_n = 1'b1;
    unlock3(8'hA0); bus_wr(BT, 16'h4321); idle(12);
    bus_rd(BT, v); chk(5, v, 16'h4321);
    wp_n = 1'b0;
    erase_pre; bus_wr(BT, 16'h0030);
    bus_rd(BT, v); chk(5, v, 16'h4321);
    erase_pre; bus_wr(22'h000555, 16'h0010);
    idle(EC + 4);
    bus_rd(BT, v); chk(5, v, 16'h4321);
    bus_rd(X1, v); chk(5, v, 16'hFFFF);
    wp_n = 1'b1;

    // R10 device reset drops a partial sequence
    bus_wr(22'h000555, 16'h00AA); bus_wr(22'h0002AA, 16'h0055);
    @(negedge clk); hw_rst_n = 1'b0; @(negedge clk); hw_rst_n = 1'b1;
    bus_wr(22'h000555, 16'h00A0); bus_wr(X2, 16'h0000);
    idle(12);
    bus_rd(X2, v); chk(10, v, 16'hFFFF);
    // R10 device reset abandons a running program
    unlock3(8'hA0); bus_wr(X2, 16'h0000);
    idle(2);
    @(negedge clk); hw_rst_n = 1'b0; @(negedge clk); hw_rst_n = 1'b1;
    bus_rd(X2, v); chk(10, v, 16'hFFFF);
    idle(12);
    bus_rd(X2, v); chk(10, v, 16'hFFFF);
    bus_rd(BT, v); chk(10, v, 16'h4321);

    // R11 one enable high keeps the bus quiet
    @(negedge clk); ce_n = 1'b1; oe_n = 1'b0; addr = BT;
    #1 chk(11, {15'd0, rdata_oe}, 16'h0000); chk(11, rdata, 16'h0000);
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b1;
    #1 chk(11, {15'd0, rdata_oe}, 16'h0000);
    @(negedge clk); ce_n = 1'b1;

    // R12 power-on reset empties the array
    @(negedge clk); rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
    bus_rd(BT, v); chk(12, v, 16'hFFFF);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule